// File: doc/BRIEF.md
# 64-bit Up-Counting Alarm Timer

This peripheral keeps a 64-bit count that rises by one on every cycle where the timer is switched on and the tick qualifier `tick_en` is high. A 64-bit target value, the running count, a small control word and one interrupt-pending flag are all reachable over a plain 32-bit register bus. Every 64-bit quantity is split into a low word and a high word.

In the free-running mode the count ignores the target and simply wraps. In the target mode the count stops when it reaches the target value and sets a sticky pending flag. The flag drives the interrupt line only while the mask bit in the control word allows it. If software later writes a larger target, the count carries on from where it stopped. Switching the timer off freezes the count. Switching it back on starts the count again from zero.

The count words have no snapshot latch. Software reads the high word, then the low word, then the high word again, and retries if the two high reads differ.

Top module: `up_alarm_timer`

## Requirements
- R1: After reset every mapped register reads 0, the count is 0, the timer is off and `irq_o` is low.
- R2: The count rises by exactly one on each clock edge where control bit 0 (run) is 1 and `tick_en` is 1. On any other edge the count does not change.
- R3: With control bit 1 (target mode) set, on the tick where the count reaches the target it stops at the target, stays there, and sets status bit 0.
- R4: `irq_o` is high exactly when status bit 0 and control bit 2 (unmask) are both 1. It changes in the same cycle as the register it follows. Status bit 0 can be read whatever the mask.
- R5: Writing 1 to status bit 0 (offset 0x18) clears it. Writing 0 there has no effect. A target hit on the same edge as a clear leaves the bit set.
- R6: Writing control with bit 0 cleared freezes the count. A control write that sets bit 0 while the timer is off restarts the count from 0.
- R7: With control bit 1 clear, the count passes the target without stopping and status is not set.
- R8: After a stop, writing a larger target makes the count resume upward from the held value, with no reload and no clear.
- R9: Read data is registered and appears one cycle after the read strobe. Offset 0x08 returns count bits 31:0 and offset 0x0C returns count bits 63:32.
- R10: Reads of unmapped offsets (for example 0x14 and 0x1C) return 0. Writes to them change nothing.
- R11: The target is written as two independent words, low at 0x00 and high at 0x04. Writing one word leaves the other unchanged. Control occupies bits 2:0 at 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Qualifies counting; one count per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid one cycle after `bus_rd` |
| irq_o | output | 1 | Interrupt: pending AND unmasked |

## Verification
Two functions can fall on the same clock edge: setting the pending flag when a tick reaches the target, and the software clear of that flag. The bench forces them together. It programs a target one above the held count, then in a single cycle raises `tick_en` and writes 1 to the status word. The result is judged by reading the status, which must still be 1, and by sampling `irq_o`, which must stay high while the timer is unmasked.

// File: rtl/uat_pkg.sv
package uat_pkg;
  localparam int unsigned OFF_TGT  = 'h00;
  localparam int unsigned OFF_CNT  = 'h08;
  localparam int unsigned OFF_CTRL = 'h10;
  localparam int unsigned OFF_STAT = 'h18;
  localparam int unsigned STRIDE   = 4;

  typedef struct packed {
    logic unmask;
    logic tgt_mode;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/uat_regs.sv
module uat_regs
  import uat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              pend,
  output logic [CNT_W-1:0]  tgt,
  output ctrl_t             ctrl,
  output logic              restart,
  output logic              pend_clr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned WORDS = CNT_W / DATA_W;

  logic [DATA_W-1:0] tgt_q [WORDS];
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ctrl_hit;

  assign ctrl_hit = wr && (addr == ADDR_W'(OFF_CTRL));
  assign restart  = ctrl_hit && wdata[0] && !ctrl_q.run;
  assign pend_clr = wr && (addr == ADDR_W'(OFF_STAT)) && wdata[0];

  for (genvar i = 0; i < WORDS; i++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (rst) begin
        tgt_q[i] <= '0;
      end else if (wr && (addr == ADDR_W'(OFF_TGT + STRIDE * i))) begin
        tgt_q[i] <= wdata;
      end
    end
    assign tgt[i*DATA_W +: DATA_W] = tgt_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_hit) begin
      ctrl_q <= ctrl_t'(wdata[2:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= '0;
      for (int i = 0; i < WORDS; i++) begin
        if (addr == ADDR_W'(OFF_TGT + STRIDE * i)) rdata_q <= tgt_q[i];
        if (addr == ADDR_W'(OFF_CNT + STRIDE * i)) rdata_q <= cnt[i*DATA_W +: DATA_W];
      end
      if (addr == ADDR_W'(OFF_CTRL)) rdata_q <= DATA_W'(ctrl_q);
      if (addr == ADDR_W'(OFF_STAT)) rdata_q <= DATA_W'(pend);
    end
  end

  assign ctrl  = ctrl_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/uat_counter.sv
module uat_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tgt_mode,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] tgt,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             parked;
  logic             step;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign parked  = tgt_mode && (cnt_q == tgt);
  assign step    = run && tick && !parked;
  assign hit     = step && tgt_mode && (cnt_inc == tgt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_inc;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/uat_irq.sv
module uat_irq (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  input  logic unmask_nxt,
  output logic pend,
  output logic irq
);
  logic pend_q, pend_d, irq_q;

  assign pend_d = hit || (pend_q && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= pend_d && unmask_nxt;
    end
  end

  assign pend = pend_q;
  assign irq  = irq_q;
endmodule

// File: rtl/up_alarm_timer.sv
module up_alarm_timer
  import uat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [CNT_W-1:0] tgt, cnt;
  ctrl_t            ctrl;
  logic             restart, pend_clr, pend, hit, unmask_nxt;

  assign unmask_nxt = (bus_wr && (bus_addr == ADDR_W'(OFF_CTRL))) ? bus_wdata[2] : ctrl.unmask;

  uat_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt), .pend(pend), .tgt(tgt), .ctrl(ctrl),
    .restart(restart), .pend_clr(pend_clr), .rdata(bus_rdata)
  );

  uat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctrl.run), .tgt_mode(ctrl.tgt_mode),
    .tick(tick_en), .restart(restart), .tgt(tgt), .cnt(cnt), .hit(hit)
  );

  uat_irq u_irq (
    .clk(clk), .rst(rst), .hit(hit), .clr(pend_clr),
    .unmask_nxt(unmask_nxt), .pend(pend), .irq(irq_o)
  );
endmodule

// File: rtl/uat_checker.sv
module uat_checker #(
  parameter int unsigned CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             tgt_mode,
  input logic             unmask,
  input logic             tick_en,
  input logic             restart,
  input logic             pend_clr,
  input logic             pend,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tgt
);
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (run && tick_en && !tgt_mode && !restart) |=> (cnt == $past(cnt) + CNT_W'(1)));

  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(cnt));

  a_r3_park: assert property (@(posedge clk) disable iff (rst)
    (run && tgt_mode && (cnt == tgt) && !restart) |=> $stable(cnt));

  a_r3_pend_at_tgt: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> (cnt == tgt));

  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (pend && !pend_clr) |=> pend);

  a_r4_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq_o == (pend && unmask));
endmodule

bind up_alarm_timer uat_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(ctrl.run), .tgt_mode(ctrl.tgt_mode),
  .unmask(ctrl.unmask), .tick_en(tick_en), .restart(restart),
  .pend_clr(pend_clr), .pend(pend), .irq_o(irq_o), .cnt(cnt), .tgt(tgt)
);

// File: tb/up_alarm_timer_bench.sv
module up_alarm_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  up_alarm_timer u_up_alarm_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), d);
      check("R1 reset register", d, 32'h0);
    end
    check("R1 reset irq", 32'(irq_o), 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(5'h10, 32'h1);
    repeat (5) @(negedge clk);
    rd(5'h08, d); check("R2 no tick no count", d, 0);
    ticks(10);
    rd(5'h08, d); check("R2 ten ticks", d, 10);
    rd(5'h0C, d); check("R9 count high word", d, 0);
  endtask

  task automatic t_stop_restart();
    logic [31:0] d;
    wr(5'h10, 32'h0);
    ticks(5);
    rd(5'h08, d); check("R6 frozen when off", d, 10);
    wr(5'h10, 32'h1);
    rd(5'h08, d); check("R6 restart from zero", d, 0);
    ticks(3);
    rd(5'h08, d); check("R6 counts after restart", d, 3);
  endtask

  task automatic t_free_mode();
    logic [31:0] d;
    wr(5'h10, 32'h0);
    wr(5'h00, 32'h2);
    wr(5'h10, 32'h1);
    ticks(5);
    rd(5'h08, d); check("R7 passes target", d, 5);
    rd(5'h18, d); check("R7 no pending", d, 0);
  endtask

  task automatic t_target_stop();
    logic [31:0] d;
    wr(5'h10, 32'h0);
    wr(5'h00, 32'h7);
    wr(5'h10, 32'h3);
    ticks(10);
    rd(5'h08, d); check("R3 stops at target", d, 7);
    rd(5'h18, d); check("R3 pending set", d, 1);
    check("R4 masked irq low", 32'(irq_o), 0);
    wr(5'h10, 32'h7);
    check("R4 unmasked irq high", 32'(irq_o), 1);
    rd(5'h08, d); check("R6 no restart while running", d, 7);
  endtask

  task automatic t_resume();
    logic [31:0] d;
    wr(5'h00, 32'd12);
    ticks(10);
    rd(5'h08, d); check("R8 resumes from held value", d, 12);
    rd(5'h18, d); check("R5 pending stays set", d, 1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(5'h18, 32'h0);
    rd(5'h18, d); check("R5 write 0 ignored", d, 1);
    wr(5'h18, 32'h1);
    rd(5'h18, d); check("R5 write 1 clears", d, 0);
    check("R4 irq low after clear", 32'(irq_o), 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(5'h00, 32'd13);
    @(negedge clk);
    tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 5'h18; bus_wdata = 32'h1;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    check("R5 hit beats clear irq", 32'(irq_o), 1);
    rd(5'h18, d); check("R5 hit beats clear", d, 1);
    rd(5'h08, d); check("R3 reached new target", d, 13);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h14, d); check("R10 unmapped read 0x14", d, 0);
    rd(5'h1C, d); check("R10 unmapped read 0x1C", d, 0);
    rd(5'h10, d); check("R10 control untouched", d, 7);
    rd(5'h00, d); check("R10 target untouched", d, 13);
  endtask

  task automatic t_halves();
    logic [31:0] d;
    wr(5'h04, 32'h0000_ABCD);
    rd(5'h04, d); check("R11 target high", d, 32'hABCD);
    rd(5'h00, d); check("R11 target low kept", d, 13);
    rd(5'h0C, d); check("R9 count high still 0", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_stop_restart();
    t_free_mode();
    t_target_stop();
    t_resume();
    t_clear();
    t_collide();
    t_unmapped();
    t_halves();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule